// File: doc/BRIEF.md
# SPI Controller Interrupt Aggregator

This block holds the interrupt state of a memory-mapped SPI controller. A master-level gate, a sticky status word, a per-source enable word and a keyed soft-reset register sit on a simple 32-bit register bus. The bus offers single-cycle read and write strobes. The FIFO engine reports two level conditions: the receive queue holds data, and the receive queue is full. It also sends two single-cycle events: a receive overrun and the transmit queue draining empty. The block folds these into status bits and drives one registered, level-sensitive interrupt line.

Software clears a status bit by writing a 1 to that bit of the status register. Each 1 in the written word inverts the matching bit, so writing the same pattern twice restores the original contents. The two receive-level conditions are not latched continuously. They are sampled into the status word on every bus access, read or write, to any offset. A write of one key value to the soft-reset register clears the register file and pulses a reset request to the rest of the controller. Any other value written there does nothing.

Top module: `spi_irq_ctrl`

## Requirements
- R1: After the asynchronous active-low reset, the master gate, the status word and the enable word read as zero, and `irq` and `soft_rst` are low.
- R2: Decode uses byte offsets with the two low address bits required to be zero. 0x1C is the master gate: only bit 31 is stored. 0x20 is status and 0x28 is enable: both hold only bits 8, 6, 5, 4, 3 and 2, a mask of 0x17C. Reads of offset 0x40, of unmapped offsets and of misaligned addresses return zero. Read data is combinational and shows the state before the same cycle's update.
- R3: A write to offset 0x20 XORs the written word, masked to 0x17C, into the status word.
- R4: A pulse on `rx_overrun_evt` sets status bit 5, and a pulse on `tx_empty_evt` sets status bit 2. Both bits stay set until software toggles them. When an event and a status write that would clear the same bit arrive in the same cycle, the event wins.
- R5: On any cycle with `bus_rd` or `bus_wr` high, status bit 8 is set if `rx_not_empty` is high and status bit 4 is set if `rx_full` is high. This also happens when the same write toggles the bit. With no access, these inputs leave the status word unchanged.
- R6: `irq` is high exactly when master gate bit 31 is set and the status and enable words share a set bit. It is registered and changes on the same clock edge as the registers that cause the change.
- R7: A write of 0x0000000A to offset 0x40 clears the gate, enable and status words, drops same-cycle events, and still applies the R5 level sampling of that access. It raises `soft_rst` for the following cycle. A write of any other value to 0x40 has no effect.
- R8: Writes to unmapped or misaligned addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (7) | Byte address inside the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high |
| rx_not_empty | input | 1 | Level: the receive queue holds data |
| rx_full | input | 1 | Level: the receive queue is full |
| rx_overrun_evt | input | 1 | One-cycle pulse: a received word was dropped |
| tx_empty_evt | input | 1 | One-cycle pulse: the transmit queue drained |
| irq | output | 1 | Registered interrupt line |
| soft_rst | output | 1 | One-cycle reset request to the rest of the controller |

## Verification
Three update sources can strike the status word in the same cycle: a software toggle, an event pulse, and the level sampling of the access itself. The bench provokes these collisions directly. It drives an overrun pulse in the same cycle as a status write that toggles bit 5, with the bit both set and clear beforehand. It also writes a toggle of bit 8 while `rx_not_empty` is high. The bit must end set in every case. Its value is read back through the status register and cross-checked on `irq` with only that bit enabled.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int WORD_W = 32;

    // register byte offsets
    localparam logic [6:0] OFS_GATE = 7'h1C;
    localparam logic [6:0] OFS_STAT = 7'h20;
    localparam logic [6:0] OFS_ENAB = 7'h28;
    localparam logic [6:0] OFS_KEY  = 7'h40;

    // status bit positions
    localparam int BIT_RXNE   = 8;
    localparam int BIT_TXHALF = 6;
    localparam int BIT_OVR    = 5;
    localparam int BIT_RXFULL = 4;
    localparam int BIT_UNDR   = 3;
    localparam int BIT_TXEMP  = 2;
    localparam int BIT_GATE   = WORD_W - 1;

    localparam logic [WORD_W-1:0] SRC_MASK =
        (WORD_W'(1) << BIT_RXNE)   | (WORD_W'(1) << BIT_TXHALF) |
        (WORD_W'(1) << BIT_OVR)    | (WORD_W'(1) << BIT_RXFULL) |
        (WORD_W'(1) << BIT_UNDR)   | (WORD_W'(1) << BIT_TXEMP);

    localparam logic [WORD_W-1:0] RESET_KEY = 32'h0000_000A;

    typedef struct packed {
        logic gate;
        logic stat;
        logic enab;
        logic key;
    } sel_t;

    typedef struct packed {
        logic              gate;
        logic [WORD_W-1:0] enab;
        logic              srst;
    } cfg_t;

endpackage

// File: rtl/spi_irq_decode.sv
module spi_irq_decode
    import spi_irq_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output sel_t              hit,
    output sel_t              wr_sel,
    output logic              access,
    output logic              key_ok
);

    localparam int CMP_W = (ADDR_W < 7) ? ADDR_W : 7;

    logic aligned;

    always_comb begin
        aligned  = (bus_addr[1:0] == 2'b00);
        hit.gate = aligned && (bus_addr == ADDR_W'(OFS_GATE[CMP_W-1:0]));
        hit.stat = aligned && (bus_addr == ADDR_W'(OFS_STAT[CMP_W-1:0]));
        hit.enab = aligned && (bus_addr == ADDR_W'(OFS_ENAB[CMP_W-1:0]));
        hit.key  = aligned && (bus_addr == ADDR_W'(OFS_KEY[CMP_W-1:0]));
        wr_sel.gate = bus_wr && hit.gate;
        wr_sel.stat = bus_wr && hit.stat;
        wr_sel.enab = bus_wr && hit.enab;
        wr_sel.key  = bus_wr && hit.key;
        access   = bus_wr || bus_rd;
        key_ok   = wr_sel.key && (bus_wdata == RESET_KEY);
    end

endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
    import spi_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              tog_we,
    input  logic [WORD_W-1:0] tog_val,
    input  logic              access,
    input  logic              rx_not_empty,
    input  logic              rx_full,
    input  logic              ovr_evt,
    input  logic              txe_evt,
    output logic [WORD_W-1:0] stat_d,
    output logic [WORD_W-1:0] stat_q
);

    logic [WORD_W-1:0] level_set;
    logic [WORD_W-1:0] event_set;

    always_comb begin
        level_set = '0;
        event_set = '0;
        if (access) begin
            level_set[BIT_RXNE]   = rx_not_empty;
            level_set[BIT_RXFULL] = rx_full;
        end
        event_set[BIT_OVR]   = ovr_evt;
        event_set[BIT_TXEMP] = txe_evt;

        if (clear) begin
            stat_d = level_set;
        end else begin
            stat_d = stat_q;
            if (tog_we) begin
                stat_d = stat_d ^ (tog_val & SRC_MASK);
            end
            stat_d = stat_d | event_set | level_set;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    // R4: an overrun pulse outside a soft reset leaves bit 5 set
    a_r4_overrun_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_evt && !clear) |=> stat_q[BIT_OVR]);

    // R4: a drain pulse outside a soft reset leaves bit 2 set
    a_r4_drain_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (txe_evt && !clear) |=> stat_q[BIT_TXEMP]);

    // R5: an access while data waits leaves bit 8 set
    a_r5_level_resample: assert property (@(posedge clk) disable iff (!rst_n)
        (access && rx_not_empty) |=> stat_q[BIT_RXNE]);

    // R5: without an access and without events, status only moves by toggle or clear
    a_r5_no_access_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!access && !ovr_evt && !txe_evt) |=> $stable(stat_q));

endmodule

// File: rtl/spi_irq_cfg.sv
module spi_irq_cfg
    import spi_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  sel_t              wr_sel,
    input  logic              key_ok,
    input  logic [WORD_W-1:0] bus_wdata,
    output cfg_t              cfg_d,
    output cfg_t              cfg_q
);

    always_comb begin
        cfg_d      = cfg_q;
        cfg_d.srst = 1'b0;
        if (key_ok) begin
            cfg_d.gate = 1'b0;
            cfg_d.enab = '0;
            cfg_d.srst = 1'b1;
        end else begin
            if (wr_sel.gate) begin
                cfg_d.gate = bus_wdata[BIT_GATE];
            end
            if (wr_sel.enab) begin
                cfg_d.enab = bus_wdata & SRC_MASK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // R7: while the reset request is out, gate and enable are cleared
    a_r7_key_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.srst |-> (!cfg_q.gate && (cfg_q.enab == '0)));

    // R7: the reset request follows only a key hit
    a_r7_key_only: assert property (@(posedge clk) disable iff (!rst_n)
        !key_ok |=> !cfg_q.srst);

endmodule

// File: rtl/spi_irq_out.sv
module spi_irq_out
    import spi_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gate_d,
    input  logic [WORD_W-1:0] enab_d,
    input  logic [WORD_W-1:0] stat_d,
    output logic              irq_q
);

    logic irq_d;

    always_comb begin
        irq_d = gate_d && (|(enab_d & stat_d));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= irq_d;
        end
    end

endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
    import spi_irq_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_not_empty,
    input  logic              rx_full,
    input  logic              rx_overrun_evt,
    input  logic              tx_empty_evt,
    output logic              irq,
    output logic              soft_rst
);

    sel_t              hit;
    sel_t              wr_sel;
    logic              access;
    logic              key_ok;
    logic [WORD_W-1:0] stat_d;
    logic [WORD_W-1:0] stat_q;
    cfg_t              cfg_d;
    cfg_t              cfg_q;
    logic              irq_q;

    spi_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .hit       (hit),
        .wr_sel    (wr_sel),
        .access    (access),
        .key_ok    (key_ok)
    );

    spi_irq_status u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (key_ok),
        .tog_we       (wr_sel.stat),
        .tog_val      (bus_wdata),
        .access       (access),
        .rx_not_empty (rx_not_empty),
        .rx_full      (rx_full),
        .ovr_evt      (rx_overrun_evt),
        .txe_evt      (tx_empty_evt),
        .stat_d       (stat_d),
        .stat_q       (stat_q)
    );

    spi_irq_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_sel    (wr_sel),
        .key_ok    (key_ok),
        .bus_wdata (bus_wdata),
        .cfg_d     (cfg_d),
        .cfg_q     (cfg_q)
    );

    spi_irq_out u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .gate_d (cfg_d.gate),
        .enab_d (cfg_d.enab),
        .stat_d (stat_d),
        .irq_q  (irq_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (hit.gate) begin
                bus_rdata[BIT_GATE] = cfg_q.gate;
            end else if (hit.stat) begin
                bus_rdata = stat_q;
            end else if (hit.enab) begin
                bus_rdata = cfg_q.enab;
            end
        end
    end

    assign irq      = irq_q;
    assign soft_rst = cfg_q.srst;

    // R6: the line is high only with the gate open and a shared set bit
    a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cfg_q.gate && (|(cfg_q.enab & stat_q))));

    // R6: a closed gate keeps the line low
    a_r6_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.gate |-> !irq);

    // R2: the stored words never carry bits outside the source mask
    a_r2_mask_only: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ~SRC_MASK) == '0) && ((cfg_q.enab & ~SRC_MASK) == '0));

endmodule

// File: tb/sim_spi_irq_ctrl.sv
module sim_spi_irq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MASK = 32'h0000_017C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_not_empty = 1'b0;
    logic        rx_full = 1'b0;
    logic        rx_overrun_evt = 1'b0;
    logic        tx_empty_evt = 1'b0;
    logic        irq;
    logic        soft_rst;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_stat = '0;
    logic [31:0] m_en = '0;
    logic        m_gate = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_not_empty(rx_not_empty), .rx_full(rx_full),
        .rx_overrun_evt(rx_overrun_evt), .tx_empty_evt(tx_empty_evt),
        .irq(irq), .soft_rst(soft_rst)
    );

    function automatic logic [31:0] spread(input int k);
        logic [31:0] v = '0;
        v[2] = k[0]; v[3] = k[1]; v[4] = k[2];
        v[5] = k[3]; v[6] = k[4]; v[8] = k[5];
        return v;
    endfunction

    function automatic logic exp_irq();
        return m_gate && (|(m_stat & m_en));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 soft_rst", {31'b0, soft_rst}, 32'h0);
        rd(7'h1C, r); check("R1 gate", r, 32'h0);
        rd(7'h20, r); check("R1 status", r, 32'h0);
        rd(7'h28, r); check("R1 enable", r, 32'h0);

        // R2 storage widths
        wr(7'h1C, 32'hFFFF_FFFF); m_gate = 1'b1;
        rd(7'h1C, r); check("R2 gate bit31 only", r, 32'h8000_0000);
        wr(7'h28, 32'hFFFF_FFFF); m_en = MASK;
        rd(7'h28, r); check("R2 enable mask", r, MASK);
        rd(7'h40, r); check("R2 key reads zero", r, 32'h0);
        rd(7'h24, r); check("R2 unmapped reads zero", r, 32'h0);
        rd(7'h29, r); check("R2 misaligned reads zero", r, 32'h0);

        // R8 unmapped and misaligned writes
        wr(7'h24, 32'hFFFF_FFFF);
        wr(7'h00, 32'hFFFF_FFFF);
        wr(7'h7C, 32'hFFFF_FFFF);
        wr(7'h21, 32'hFFFF_FFFF);
        wr(7'h29, 32'h0);
        wr(7'h1D, 32'h0);
        rd(7'h20, r); check("R8 status untouched", r, 32'h0);
        rd(7'h28, r); check("R8 enable untouched", r, MASK);
        rd(7'h1C, r); check("R8 gate untouched", r, 32'h8000_0000);
        check("R8 irq low", {31'b0, irq}, 32'h0);

        // R3/R6 sweep over all source patterns
        for (int k = 0; k < 64; k++) begin
            logic [31:0] t;
            t = spread(k) | (k[0] ? 32'hFFFF_0000 : 32'h0);
            wr(7'h20, t); m_stat = m_stat ^ (t & MASK);
            check("R6 irq after toggle", {31'b0, irq}, {31'b0, exp_irq()});
            wr(7'h28, spread((k * 5 + 3) & 63)); m_en = spread((k * 5 + 3) & 63);
            check("R6 irq after enable", {31'b0, irq}, {31'b0, exp_irq()});
            wr(7'h1C, {k[1], 31'h0}); m_gate = k[1];
            check("R6 irq after gate", {31'b0, irq}, {31'b0, exp_irq()});
            rd(7'h20, r); check("R3 status toggle", r, m_stat);
        end

        // R3 double toggle restores
        wr(7'h20, 32'h0000_0128); m_stat = m_stat ^ 32'h128;
        wr(7'h20, 32'h0000_0128); m_stat = m_stat ^ 32'h128;
        rd(7'h20, r); check("R3 double toggle", r, m_stat);

        // clear status for the event tests
        wr(7'h20, m_stat); m_stat = '0;
        wr(7'h28, 32'h0000_0020); m_en = 32'h20;
        wr(7'h1C, 32'h8000_0000); m_gate = 1'b1;

        // R4 pulse with no access sets bit 5 and irq
        @(negedge clk); rx_overrun_evt = 1'b1;
        @(negedge clk); rx_overrun_evt = 1'b0; m_stat[5] = 1'b1;
        check("R4 overrun irq", {31'b0, irq}, 32'h1);
        repeat (3) @(negedge clk);
        check("R4 overrun sticky", {31'b0, irq}, 32'h1);

        // R4 collision: toggle of a set bit 5 together with a pulse
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 7'h20; bus_wdata = 32'h20; rx_overrun_evt = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; rx_overrun_evt = 1'b0;
        rd(7'h20, r); check("R4 event beats toggle (set)", r, 32'h20);
        // clear, then collision with bit 5 clear
        wr(7'h20, 32'h20);
        rd(7'h20, r); check("R4 toggle clears", r, 32'h0);
        check("R4 irq drops", {31'b0, irq}, 32'h0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 7'h20; bus_wdata = 32'h20; rx_overrun_evt = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; rx_overrun_evt = 1'b0;
        rd(7'h20, r); check("R4 event beats toggle (clear)", r, 32'h20);
        wr(7'h20, 32'h20);

        // R4 drain pulse
        @(negedge clk); tx_empty_evt = 1'b1;
        @(negedge clk); tx_empty_evt = 1'b0;
        rd(7'h20, r); check("R4 drain sets bit2", r, 32'h04);
        wr(7'h20, 32'h04);

        // R5 levels without access do nothing
        wr(7'h28, 32'h100); m_en = 32'h100;
        @(negedge clk); rx_not_empty = 1'b1;
        repeat (4) @(negedge clk);
        check("R5 no access no set", {31'b0, irq}, 32'h0);
        rd(7'h24, r);
        check("R5 read returns pre-update", r, 32'h0);
        check("R5 access sets bit8 irq", {31'b0, irq}, 32'h1);
        rd(7'h20, r); check("R5 status bit8", r, 32'h100);
        // toggle while level holds: re-sampled
        wr(7'h20, 32'h100);
        rd(7'h20, r); check("R5 level beats toggle", r, 32'h100);
        rx_not_empty = 1'b0;
        wr(7'h20, 32'h100);
        rd(7'h20, r); check("R5 toggle clears once level gone", r, 32'h0);
        @(negedge clk); rx_full = 1'b1;
        wr(7'h7C, 32'h0);
        rd(7'h20, r); check("R5 full via write access", r, 32'h10);
        rx_full = 1'b0;
        wr(7'h20, 32'h10);

        // R7 wrong key ignored
        wr(7'h40, 32'h0000_000B);
        check("R7 wrong key no pulse", {31'b0, soft_rst}, 32'h0);
        rd(7'h1C, r); check("R7 wrong key gate kept", r, 32'h8000_0000);
        rd(7'h28, r); check("R7 wrong key enable kept", r, 32'h100);

        // R7 key with a full receive queue and a same-cycle event
        wr(7'h20, 32'h44);
        @(negedge clk);
        rx_full = 1'b1;
        bus_wr = 1'b1; bus_addr = 7'h40; bus_wdata = 32'h0000_000A; tx_empty_evt = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tx_empty_evt = 1'b0; rx_full = 1'b0;
        check("R7 soft_rst pulse", {31'b0, soft_rst}, 32'h1);
        check("R7 irq low", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R7 soft_rst one cycle", {31'b0, soft_rst}, 32'h0);
        rd(7'h1C, r); check("R7 gate cleared", r, 32'h0);
        rd(7'h28, r); check("R7 enable cleared", r, 32'h0);
        rd(7'h20, r); check("R7 status keeps level only", r, 32'h10);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule